// File: doc/BRIEF.md
# System Identification and Status Register Bank

This block is a small memory-mapped bank of identification and status words for a console-style system controller. Boot firmware reads it to check which chip revision it is running on, which sales region the board was strapped for, and which video cable is fitted. It sits on a simple 32-bit register port: one request per cycle, with a separate write enable and a word offset. Each read returns its data together with a one-cycle valid strobe on the following cycle.

Most words are fixed constants that writes cannot alter. A region code and a 2-bit video-cable code are sampled from strap pins while reset is held. They are then frozen, and the cable code is mirrored into two registers at different bit positions. A 16-bit refresh counter moves forward by a fixed step on every read of its offset. Firmware that polls it during self-test always sees it change.

Top module: `sysid_regbank`

## Requirements
- R1: Word offsets 0x0, 0x1, 0x2 and 0x3 read as 0x0000000B (system bus revision), 0x00000012 (expansion bus ID), 0x17FD11DB (device ID) and 0x00000011 (chip revision).
- R2: Writes to offsets 0x0–0x5 and 0x7–0x9 are ignored, and a later read of those offsets returns the same value it would have returned without the write.
- R3: Offset 0x4 (system mode) reads a region word decoded from the 2-bit region strap: 0 gives 0x00002000, 1 gives 0x00000800, 2 gives 0x00006000, and 3 gives 0x00002000.
- R4: The region and cable straps are sampled only while reset is asserted. Changes on the strap pins after reset release have no effect on any register.
- R5: Offset 0x5 (FIFO remaining) always reads 0x00000008.
- R6: Offset 0x6 (sync control) reads the 2-bit cable code in bits 7:6 (0 = VGA, 2 = RGB/SCART, 3 = composite/RF). All its other bits are software-writable and reset to zero. Writes to bits 7:6 are ignored.
- R7: Offset 0x7 (AV control) reads (cable << 8) | 0x1.
- R8: Offset 0x8 (refresh counter) resets to zero. Each read returns the current 16-bit value, zero-extended, and then advances it by 0x20, wrapping modulo 2^16. No other access changes it.
- R9: Offset 0x9 (cache controller status) always reads 0x00000080.
- R10: Offsets 0xA–0xF read zero. A read request gives bus_rvalid high for exactly the next cycle, with bus_rdata valid in that cycle. Writes raise no bus_rvalid. bus_rdata is zero whenever bus_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_region | input | 2 | Region strap pins, sampled during reset |
| strap_cable | input | 2 | Video-cable strap pins, sampled during reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-completion strobe |

## Verification
The assertions assume that the strap pins hold steady during the last two clock cycles of reset, so that the captured value is well defined. The stimulus sets the straps before reset is asserted and changes them only after release. The assertions also assume that the clock runs while reset is low, because the straps are captured on clock edges; the bench clock runs freely from time zero. Accesses are issued only once the synchronised reset has been released, with at least one idle cycle between requests.

// File: rtl/sysid_pkg.sv
package sysid_pkg;
  localparam int DATA_W    = 32;
  localparam int CABLE_W   = 2;
  localparam int REGION_W  = 2;
  localparam int CABLE_LSB = 6;
  localparam int AV_SHIFT  = 8;

  localparam logic [DATA_W-1:0] K_SBUS_REV  = 32'h0000_000B;
  localparam logic [DATA_W-1:0] K_XBUS_ID   = 32'h0000_0012;
  localparam logic [DATA_W-1:0] K_DEVICE_ID = 32'h17FD_11DB;
  localparam logic [DATA_W-1:0] K_CHIP_REV  = 32'h0000_0011;
  localparam logic [DATA_W-1:0] K_FIFO_REM  = 32'h0000_0008;
  localparam logic [DATA_W-1:0] K_CACHE_ST  = 32'h0000_0080;

  typedef enum int {
    OFS_SBUS_REV = 0, OFS_XBUS_ID = 1, OFS_DEVICE_ID = 2, OFS_CHIP_REV = 3,
    OFS_SYSMODE  = 4, OFS_FIFO_REM = 5, OFS_SYNC_CTL = 6, OFS_AV_CTL = 7,
    OFS_REFRESH  = 8, OFS_CACHE_ST = 9
  } reg_ofs_e;

  function automatic logic [DATA_W-1:0] region_word(input logic [REGION_W-1:0] code);
    case (code)
      2'd1:    return 32'h0000_0800;
      2'd2:    return 32'h0000_6000;
      default: return 32'h0000_2000;
    endcase
  endfunction
endpackage

// File: rtl/sysid_rst_sync.sv
module sysid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/sysid_strap_latch.sv
module sysid_strap_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n_s,
  input  logic [W-1:0] strap_in,
  output logic [W-1:0] strap_q
);
  logic         cap_en;
  logic [W-1:0] strap_d;

  always_comb begin
    cap_en  = ~rst_n_s;
    strap_d = cap_en ? strap_in : strap_q;
  end

  always_ff @(posedge clk) strap_q <= strap_d;

  // R4: once out of reset for a full cycle, the captured straps never move
  p_strap_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> $stable(strap_q));
endmodule

// File: rtl/sysid_refresh_ctr.sv
module sysid_refresh_ctr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] STEP = 16'h0020
) (
  input  logic         clk,
  input  logic         rst_n_s,
  input  logic         adv,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;

  always_comb cnt_d = adv ? cnt_q + STEP : cnt_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  p_adv_step_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    adv |=> cnt_q == $past(cnt_q) + STEP);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !adv |=> $stable(cnt_q));
endmodule

// File: rtl/sysid_regbank.sv
module sysid_regbank
  import sysid_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RFC_W    = 16,
  parameter int RFC_STEP = 32'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_region,
  input  logic [1:0]        strap_cable,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int STRAP_W = REGION_W + CABLE_W;
  localparam logic [DATA_W-1:0] CABLE_MASK = DATA_W'(((1 << CABLE_W) - 1) << CABLE_LSB);

  logic                rst_n_s;
  logic [STRAP_W-1:0]  strap_q;
  logic [REGION_W-1:0] region_q;
  logic [CABLE_W-1:0]  cable_q;
  logic [RFC_W-1:0]    rfc_q;
  logic                rd_req, wr_req, rfc_adv, sync_wr;
  logic [DATA_W-1:0]   sync_q, sync_d;
  logic [DATA_W-1:0]   rd_mux, rdata_d;
  logic                rvalid_d;

  sysid_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  sysid_strap_latch #(.W(STRAP_W)) u_strap (
    .clk(clk), .rst_n_s(rst_n_s),
    .strap_in({strap_region, strap_cable}), .strap_q(strap_q));

  assign region_q = strap_q[STRAP_W-1:CABLE_W];
  assign cable_q  = strap_q[CABLE_W-1:0];

  sysid_refresh_ctr #(.W(RFC_W), .STEP(RFC_W'(RFC_STEP))) u_rfc (
    .clk(clk), .rst_n_s(rst_n_s), .adv(rfc_adv), .cnt_q(rfc_q));

  always_comb begin
    rd_req  = bus_sel & ~bus_we;
    wr_req  = bus_sel & bus_we;
    rfc_adv = rd_req & (bus_addr == ADDR_W'(OFS_REFRESH));
    sync_wr = wr_req & (bus_addr == ADDR_W'(OFS_SYNC_CTL));
    sync_d  = sync_wr ? (bus_wdata & ~CABLE_MASK) : sync_q;
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      OFS_SBUS_REV:  rd_mux = K_SBUS_REV;
      OFS_XBUS_ID:   rd_mux = K_XBUS_ID;
      OFS_DEVICE_ID: rd_mux = K_DEVICE_ID;
      OFS_CHIP_REV:  rd_mux = K_CHIP_REV;
      OFS_SYSMODE:   rd_mux = region_word(region_q);
      OFS_FIFO_REM:  rd_mux = K_FIFO_REM;
      OFS_SYNC_CTL:  rd_mux = sync_q | (DATA_W'(cable_q) << CABLE_LSB);
      OFS_AV_CTL:    rd_mux = (DATA_W'(cable_q) << AV_SHIFT) | 32'h1;
      OFS_REFRESH:   rd_mux = DATA_W'(rfc_q);
      OFS_CACHE_ST:  rd_mux = K_CACHE_ST;
      default:       rd_mux = '0;
    endcase
    rdata_d  = rd_req ? rd_mux : '0;
    rvalid_d = rd_req;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sync_q     <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      sync_q     <= sync_d;
      bus_rdata  <= rdata_d;
      bus_rvalid <= rvalid_d;
    end
  end

  p_id_const_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_req && bus_addr == ADDR_W'(OFS_DEVICE_ID) |=> bus_rdata == K_DEVICE_ID);
  p_cable_field_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_req && bus_addr == ADDR_W'(OFS_SYNC_CTL) |=> bus_rdata[CABLE_LSB +: CABLE_W] == cable_q);
  p_rvalid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_req |=> bus_rvalid);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_req |=> !bus_rvalid && bus_rdata == '0);
endmodule

// File: tb/sysid_regbank_bench.sv
module sysid_regbank_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  strap_region = 2'd0;
  logic [1:0]  strap_cable = 2'd0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] rf_model;
  bit          done = 0;

  always #(PERIOD/2) clk = ~clk;

  sysid_regbank u_sysid_regbank (
    .clk(clk), .rst_n(rst_n), .strap_region(strap_region), .strap_cable(strap_cable),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read completion
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end else if (rst_n && !bus_rvalid && bus_rdata !== 32'd0) begin
      check("R10 rdata idle zero", bus_rdata, 32'd0);
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] reg_code, input logic [1:0] cab);
    @(negedge clk);
    strap_region = reg_code; strap_cable = cab;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
    check("R10 rdata in reset", bus_rdata, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rf_model = '0;
  endtask

  function automatic logic [31:0] region_exp(input logic [1:0] c);
    return c == 2'd1 ? 32'h800 : c == 2'd2 ? 32'h6000 : 32'h2000;
  endfunction

  task automatic rd_rfc(input string tag);
    rd(4'h8, {16'd0, rf_model}, tag);
    rf_model = rf_model + 16'h20;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      check("watchdog", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset(2'd0, 2'd0);
    // R1 identification constants
    rd(4'h0, 32'h0000000B, "R1 sbus rev");
    rd(4'h1, 32'h00000012, "R1 xbus id");
    rd(4'h2, 32'h17FD11DB, "R1 device id");
    rd(4'h3, 32'h00000011, "R1 chip rev");
    rd(4'h4, 32'h00002000, "R3 region 0");
    rd(4'h5, 32'h00000008, "R5 fifo rem");
    rd(4'h6, 32'h00000000, "R6 sync VGA reset");
    rd(4'h7, 32'h00000001, "R7 av VGA");
    rd(4'h9, 32'h00000080, "R9 cache status");
    rd(4'hA, 32'h0, "R10 unmapped A");
    rd(4'hF, 32'h0, "R10 unmapped F");
    // R8 counter basics
    rd_rfc("R8 rfc first");
    rd_rfc("R8 rfc second");
    rd_rfc("R8 rfc third");
    // R2 writes to read-only words ignored
    for (int a = 0; a < 10; a++) if (a != 6) wr(4'(a), 32'hFFFF_FFFF);
    rd(4'h0, 32'h0000000B, "R2 sbus rev after write");
    rd(4'h1, 32'h00000012, "R2 xbus id after write");
    rd(4'h2, 32'h17FD11DB, "R2 device id after write");
    rd(4'h3, 32'h00000011, "R2 chip rev after write");
    rd(4'h4, 32'h00002000, "R2 sysmode after write");
    rd(4'h5, 32'h00000008, "R2 fifo after write");
    rd(4'h7, 32'h00000001, "R2 av after write");
    rd(4'h9, 32'h00000080, "R2 cache after write");
    rd_rfc("R2 R8 rfc unchanged by write");
    // R6 writable bits, cable field protected
    wr(4'h6, 32'hFFFF_FFFF);
    rd(4'h6, 32'hFFFF_FF3F, "R6 sync write other bits");
    wr(4'h6, 32'h0000_00C5);
    rd(4'h6, 32'h0000_0005, "R6 sync cable bits ignored");

    // second region, RGB cable
    do_reset(2'd1, 2'd2);
    rd(4'h4, 32'h00000800, "R3 region 1");
    rd(4'h6, 32'h00000080, "R6 sync RGB");
    rd(4'h7, 32'h00000201, "R7 av RGB");
    rd_rfc("R8 rfc reset to zero");
    // R4 strap changes after reset ignored
    strap_region = 2'd2; strap_cable = 2'd3;
    repeat (3) @(negedge clk);
    rd(4'h4, 32'h00000800, "R4 region held");
    rd(4'h7, 32'h00000201, "R4 av cable held");
    rd(4'h6, 32'h00000080, "R4 sync cable held");

    // third region, composite cable
    do_reset(2'd2, 2'd3);
    rd(4'h4, 32'h00006000, "R3 region 2");
    rd(4'h6, 32'h000000C0, "R6 sync composite");
    rd(4'h7, 32'h00000301, "R7 av composite");
    do_reset(2'd3, 2'd0);
    rd(4'h4, 32'h00002000, "R3 region code 3");

    // R8 wrap after 2048 reads
    for (int i = 0; i < 2048; i++) rd_rfc("R8 rfc sweep");
    rd(4'h8, 32'h0, "R8 rfc wrapped");
    rf_model = rf_model + 16'h20;
    rd_rfc("R8 rfc after wrap");

    repeat (3) @(negedge clk);
    check("R10 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule